// File: doc/BRIEF.md
# Signalling-Channel Contention Controller

This block decides when an HDLC frame may go out on the 2-bit-per-frame signalling channel of a time-division line interface that several terminals share. When the frame source reports a pending frame, the block raises a request line to the line-interface device. It then looks at the grant line, but only in the cycle that carries the frame sync. A grant seen there starts transmission in the first signalling-channel bit slot of that frame. The block sends an opening flag, the frame bytes and a closing flag, least significant bit first. The channel idles at all ones.

The line-interface device withdraws grant when it sees a collision. The block then leaves the line on the next clock. If no more than two buffers' worth of bytes have been taken from the source, it tells the source to rewind to the first byte of the frame and sends the whole frame again after a later granted sync. If more bytes have been taken, the frame cannot be replayed. The block reports a late collision, the source discards the frame, and the block goes idle. A per-frame retry counter saturates at its maximum and raises an excessive-collision flag. CRC generation and zero-bit insertion are done elsewhere.

Top module: `dch_contend`

## Requirements
- R1: After reset, and at any time no frame is being sent, `txen_o` is 0 and `txd_o` is 1. After reset `req_o`, `src_pop_o`, `src_rewind_o`, `late_coll_o`, `frame_done_o`, `excess_coll_o` and `retry_cnt_o` are all 0.
- R2: `req_o` rises in the cycle after `src_valid_i` is seen while idle. It stays high through every attempt and collision of that frame, including the one-cycle `frame_done_o` cycle. It falls in the next cycle if no further frame is pending; if another frame is queued, it stays high with no gap.
- R3: `grant_i` is used to start a transmission only in a cycle where `frm_sync_i` is 1. A grant that rises after the sync of a frame does not start that frame, and transmission begins in the next frame instead.
- R4: A start taken at a sync drives `txen_o` from the next cycle. The first bit goes out in the first `dslot_i` cycle after that sync. The bit order is the flag 0x7E, then each source byte, then the flag 0x7E, every byte sent bit 0 first. One bit is sent per `dslot_i` cycle, and the first bit is 0.
- R5: If `grant_i` is 0 in any cycle while `txen_o` is 1, then in the next cycle `txen_o` is 0 and `txd_o` is 1.
- R6: A collision after at most 2*BUF_BYTES (8) source bytes have been taken gives a one-cycle `src_rewind_o` in the cycle after the collision. `late_coll_o` stays low. At a later granted sync the complete frame is sent again from the opening flag.
- R7: A collision after more than 2*BUF_BYTES bytes have been taken gives a one-cycle `late_coll_o` in the cycle after the collision and no `src_rewind_o`. The frame is abandoned: nothing more is popped or sent for it. If nothing else is queued, `req_o` is 0 in the following cycle.
- R8: `retry_cnt_o` rises by 1 on each rewind and saturates at 15. `excess_coll_o` is 1 exactly when the count is 15. A completed frame or a late collision clears both.
- R9: `src_pop_o` pulses once for each source byte, only in a `dslot_i` cycle while transmitting. `frame_done_o` pulses once for each frame that finishes with its closing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_sync_i | input | 1 | One-cycle pulse marking the start of a line frame |
| dslot_i | input | 1 | One-cycle strobe for each signalling-channel bit slot |
| grant_i | input | 1 | Permission to transmit from the line-interface device |
| req_o | output | 1 | Request to transmit on the signalling channel |
| txd_o | output | 1 | Serial bit for the current slot, 1 when not sending |
| txen_o | output | 1 | High while a transmission attempt is in progress |
| src_valid_i | input | 1 | Frame source has a byte of a pending frame |
| src_byte_i | input | 8 | Current source byte (show-ahead) |
| src_last_i | input | 1 | Current source byte is the last of its frame |
| src_pop_o | output | 1 | Source byte taken; advance to the next |
| src_rewind_o | output | 1 | Return the source to the first byte of the frame |
| late_coll_o | output | 1 | Late collision: frame abandoned, source discards it |
| frame_done_o | output | 1 | Frame completed with its closing flag |
| retry_cnt_o | output | 4 | Collisions suffered by the current frame, saturating |
| excess_coll_o | output | 1 | Retry count has reached its maximum |

## Verification
Clean frames of several lengths are sent with grant held high. Comparing every captured bit against flag, payload and flag shows byte order and LSB-first order, and the slot in which each frame starts shows start alignment. Grant is raised just after a sync to show that a start depends only on grant at the sync instant. Collisions after exactly 64 and exactly 72 bits fall on either side of the two-buffer replay limit, so the rewind and the abandonment paths are told apart. Sixteen early collisions in a row show the counter saturating, and two frames queued back to back show that the request line has no gap between frames.

// File: rtl/dch_pkg.sv
package dch_pkg;

    localparam int FLAG_W = 8;
    localparam logic [FLAG_W-1:0] HDLC_FLAG = 8'h7E;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_WAIT_SYNC,
        ST_SEND,
        ST_ABORT,
        ST_DONE
    } dch_state_e;

    typedef enum logic [1:0] {
        PH_OPEN,
        PH_DATA,
        PH_CLOSE
    } dch_phase_e;

endpackage

// File: rtl/dch_retry_cnt.sv
module dch_retry_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         sat_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr_i) begin
            nxt_d.cnt = '0;
        end else if (inc_i && (cur_q.cnt != CNT_MAX)) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt_o = cur_q.cnt;
    assign sat_o = (cur_q.cnt == CNT_MAX);

endmodule

// File: rtl/dch_serializer.sv
module dch_serializer
    import dch_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int CNT_SAT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              adv_i,
    input  logic [FLAG_W-1:0] byte_i,
    input  logic              last_i,
    output logic              bit_o,
    output logic              pop_o,
    output logic              end_o,
    output logic [CNT_W-1:0]  bytes_o
);
    localparam int BIT_W = $clog2(FLAG_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FLAG_W - 1);
    localparam logic [CNT_W-1:0] SAT_VAL  = CNT_W'(CNT_SAT);

    typedef struct packed {
        logic [FLAG_W-1:0] sh;
        logic [BIT_W-1:0]  bitn;
        dch_phase_e        phase;
        logic              last;
        logic [CNT_W-1:0]  bytes;
    } ser_t;

    ser_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        pop_o = 1'b0;
        end_o = 1'b0;
        if (start_i) begin
            nxt_d.sh    = HDLC_FLAG;
            nxt_d.bitn  = '0;
            nxt_d.phase = PH_OPEN;
            nxt_d.last  = 1'b0;
            nxt_d.bytes = '0;
        end else if (adv_i) begin
            if (cur_q.bitn == LAST_BIT) begin
                nxt_d.bitn = '0;
                unique case (cur_q.phase)
                    PH_OPEN, PH_DATA: begin
                        if ((cur_q.phase == PH_DATA) && cur_q.last) begin
                            nxt_d.sh    = HDLC_FLAG;
                            nxt_d.phase = PH_CLOSE;
                        end else begin
                            nxt_d.sh    = byte_i;
                            nxt_d.last  = last_i;
                            nxt_d.phase = PH_DATA;
                            pop_o       = 1'b1;
                            if (cur_q.bytes != SAT_VAL) begin
                                nxt_d.bytes = cur_q.bytes + 1'b1;
                            end
                        end
                    end
                    PH_CLOSE: end_o = 1'b1;
                    default:  nxt_d.phase = PH_OPEN;
                endcase
            end else begin
                nxt_d.sh   = cur_q.sh >> 1;
                nxt_d.bitn = cur_q.bitn + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.sh    <= '1;
            cur_q.bitn  <= '0;
            cur_q.phase <= PH_OPEN;
            cur_q.last  <= 1'b0;
            cur_q.bytes <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bit_o   = cur_q.sh[0];
    assign bytes_o = cur_q.bytes;

endmodule

// File: rtl/dch_arb_fsm.sv
module dch_arb_fsm
    import dch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic       grant_i,
    input  logic       valid_i,
    input  logic       end_i,
    input  logic       late_i,
    output dch_state_e state_o,
    output logic       start_o
);
    typedef struct packed {
        dch_state_e st;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d   = cur_q;
        start_o = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (valid_i) nxt_d.st = ST_REQUEST;
            end
            ST_REQUEST, ST_WAIT_SYNC: begin
                if (sync_i && grant_i) begin
                    nxt_d.st = ST_SEND;
                    start_o  = 1'b1;
                end
            end
            ST_SEND: begin
                if (!grant_i)   nxt_d.st = ST_ABORT;
                else if (end_i) nxt_d.st = ST_DONE;
            end
            ST_ABORT: begin
                nxt_d.st = late_i ? ST_IDLE : ST_WAIT_SYNC;
            end
            ST_DONE: begin
                nxt_d.st = valid_i ? ST_REQUEST : ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q.st <= ST_IDLE;
        else        cur_q    <= nxt_d;
    end

    assign state_o = cur_q.st;

endmodule

// File: rtl/dch_contend.sv
module dch_contend
    import dch_pkg::*;
#(
    parameter int BUF_BYTES = 4,
    parameter int RETRY_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_sync_i,
    input  logic               dslot_i,
    input  logic               grant_i,
    output logic               req_o,
    output logic               txd_o,
    output logic               txen_o,
    input  logic               src_valid_i,
    input  logic [FLAG_W-1:0]  src_byte_i,
    input  logic               src_last_i,
    output logic               src_pop_o,
    output logic               src_rewind_o,
    output logic               late_coll_o,
    output logic               frame_done_o,
    output logic [RETRY_W-1:0] retry_cnt_o,
    output logic               excess_coll_o
);
    localparam int WINDOW  = 2 * BUF_BYTES;
    localparam int CNT_SAT = WINDOW + 1;
    localparam int CNT_W   = $clog2(CNT_SAT + 1);
    localparam logic [CNT_W-1:0] WIN_VAL = CNT_W'(WINDOW);

    dch_state_e       state;
    logic             start;
    logic             sending;
    logic             adv;
    logic             ser_bit;
    logic             ser_end;
    logic [CNT_W-1:0] bytes_taken;
    logic             late;
    logic             aborting;

    assign sending  = (state == ST_SEND);
    assign adv      = sending && grant_i && dslot_i;
    assign aborting = (state == ST_ABORT);
    assign late     = (bytes_taken > WIN_VAL);

    dch_arb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (frm_sync_i),
        .grant_i (grant_i),
        .valid_i (src_valid_i),
        .end_i   (ser_end),
        .late_i  (late),
        .state_o (state),
        .start_o (start)
    );

    dch_serializer #(
        .CNT_W   (CNT_W),
        .CNT_SAT (CNT_SAT)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .adv_i   (adv),
        .byte_i  (src_byte_i),
        .last_i  (src_last_i),
        .bit_o   (ser_bit),
        .pop_o   (src_pop_o),
        .end_o   (ser_end),
        .bytes_o (bytes_taken)
    );

    dch_retry_cnt #(
        .W (RETRY_W)
    ) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (src_rewind_o),
        .clr_i (late_coll_o || frame_done_o),
        .cnt_o (retry_cnt_o),
        .sat_o (excess_coll_o)
    );

    assign req_o        = (state != ST_IDLE);
    assign txen_o       = sending;
    assign txd_o        = sending ? ser_bit : 1'b1;
    assign src_rewind_o = aborting && !late;
    assign late_coll_o  = aborting && late;
    assign frame_done_o = (state == ST_DONE);

endmodule

// File: rtl/dch_contend_chk.sv
module dch_contend_chk #(
    parameter int RETRY_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frm_sync_i,
    input logic               dslot_i,
    input logic               grant_i,
    input logic               req_o,
    input logic               txd_o,
    input logic               txen_o,
    input logic               src_pop_o,
    input logic               src_rewind_o,
    input logic               late_coll_o,
    input logic               frame_done_o,
    input logic [RETRY_W-1:0] retry_cnt_o
);
    p_idle_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !txen_o |-> txd_o);

    p_req_cover_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (txen_o || frame_done_o) |-> req_o);

    p_start_at_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txen_o) |-> $past(frm_sync_i && grant_i));

    p_first_bit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txen_o) |-> !txd_o);

    p_stop_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (txen_o && !grant_i) |=> (!txen_o && txd_o));

    p_rewind_or_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_rewind_o && late_coll_o));

    p_retry_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt_o == '1 && !frame_done_o && !late_coll_o) |=> (retry_cnt_o == '1));

    p_pop_in_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop_o |-> (txen_o && dslot_i && grant_i));

endmodule

bind dch_contend dch_contend_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_sync_i   (frm_sync_i),
    .dslot_i      (dslot_i),
    .grant_i      (grant_i),
    .req_o        (req_o),
    .txd_o        (txd_o),
    .txen_o       (txen_o),
    .src_pop_o    (src_pop_o),
    .src_rewind_o (src_rewind_o),
    .late_coll_o  (late_coll_o),
    .frame_done_o (frame_done_o),
    .retry_cnt_o  (retry_cnt_o)
);

// File: tb/dch_contend_bench.sv
`timescale 1ns/100ps
module dch_contend_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       frm_sync_i = 1'b0;
    logic       dslot_i = 1'b0;
    logic       grant_i = 1'b0;
    logic       req_o, txd_o, txen_o;
    logic       src_valid_i, src_last_i;
    logic [7:0] src_byte_i;
    logic       src_pop_o, src_rewind_o, late_coll_o, frame_done_o, excess_coll_o;
    logic [3:0] retry_cnt_o;

    dch_contend u_dch_contend (
        .clk           (clk),
        .rst_n         (rst_n),
        .frm_sync_i    (frm_sync_i),
        .dslot_i       (dslot_i),
        .grant_i       (grant_i),
        .req_o         (req_o),
        .txd_o         (txd_o),
        .txen_o        (txen_o),
        .src_valid_i   (src_valid_i),
        .src_byte_i    (src_byte_i),
        .src_last_i    (src_last_i),
        .src_pop_o     (src_pop_o),
        .src_rewind_o  (src_rewind_o),
        .late_coll_o   (late_coll_o),
        .frame_done_o  (frame_done_o),
        .retry_cnt_o   (retry_cnt_o),
        .excess_coll_o (excess_coll_o)
    );

    // frame source model
    logic [7:0] mem   [0:63];
    logic       lastm [0:63];
    int total = 0;
    int ptr = 0;
    int fstart = 0;
    assign src_valid_i = (ptr < total);
    assign src_byte_i  = mem[ptr[5:0]];
    assign src_last_i  = lastm[ptr[5:0]];

    // line timing, capture and event counters
    int ph = 9, frame_no = 0;
    logic cap [0:255];
    int cap_n = 0, cap_ph = 0, cap_fr = 0;
    int pop_cnt = 0, rew_cnt = 0, late_cnt = 0, done_cnt = 0, reqlow_cnt = 0, idle_bad = 0;
    logic pend_pop = 0, pend_rew = 0, pend_drop = 0, pend_done = 0, prev_txen = 0;

    always begin
        @(negedge clk);
        if (pend_pop) ptr = ptr + 1;
        if (pend_rew) ptr = fstart;
        if (pend_drop) begin
            int k;
            k = fstart;
            while (k < total && !lastm[k[5:0]]) k = k + 1;
            ptr = k + 1;
            fstart = ptr;
        end
        if (pend_done) fstart = ptr;
        ph = (ph == 9) ? 0 : ph + 1;
        if (ph == 0) frame_no = frame_no + 1;
        frm_sync_i = (ph == 0);
        dslot_i = (ph == 3) || (ph == 7);
        #1;
        pend_pop  = rst_n && src_pop_o;
        pend_rew  = rst_n && src_rewind_o;
        pend_drop = rst_n && late_coll_o;
        pend_done = rst_n && frame_done_o;
        if (rst_n) begin
            if (txen_o && !prev_txen) cap_n = 0;
            if (dslot_i && txen_o) begin
                if (cap_n == 0) begin
                    cap_ph = ph;
                    cap_fr = frame_no;
                end
                cap[cap_n] = txd_o;
                cap_n = cap_n + 1;
            end
            prev_txen = txen_o;
            if (src_pop_o)    pop_cnt++;
            if (src_rewind_o) rew_cnt++;
            if (late_coll_o)  late_cnt++;
            if (frame_done_o) done_cnt++;
            if (!req_o)       reqlow_cnt++;
            if (!txen_o && !txd_o) idle_bad++;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1.5;
    endtask

    task automatic add_frame(input int len, output int base);
        base = total;
        for (int j = 0; j < len; j++) begin
            mem[total + j]   = 8'h3C ^ 8'(j * 29 + len * 7);
            lastm[total + j] = (j == len - 1);
        end
        total = total + len;
    endtask

    function automatic logic exp_bit(input int base, input int len, input int i);
        int b = i / 8;
        int n = i % 8;
        logic [7:0] flag = 8'h7E;
        if (b == 0 || b == len + 1) return flag[n];
        return mem[base + b - 1][n];
    endfunction

    task automatic check_stream(input string tag, input int base, input int len);
        int bad = 0;
        chk_eq({tag, " bit count"}, cap_n, (len + 2) * 8);
        for (int i = 0; i < (len + 2) * 8 && i < cap_n; i++)
            if (cap[i] !== exp_bit(base, len, i)) bad++;
        chk_eq({tag, " bit mismatches"}, bad, 0);
    endtask

    task automatic wait_done(input int target, input string tag);
        int g = 0;
        while (done_cnt < target && g < 20000) begin
            step();
            g++;
        end
        chk_eq({tag, " frame completed"}, int'(done_cnt >= target), 1);
    endtask

    task automatic wait_bits(input int n, input string tag);
        int g = 0;
        while (!(txen_o && cap_n == n) && g < 20000) begin
            step();
            g++;
        end
        chk_eq({tag, " reached bit"}, cap_n, n);
    endtask

    task automatic t_reset();
        chk_eq("R1 reset req", req_o, 0);
        chk_eq("R1 reset txen", txen_o, 0);
        chk_eq("R1 reset txd", txd_o, 1);
        chk_eq("R1 reset pulses", src_pop_o | src_rewind_o | late_coll_o | frame_done_o, 0);
        chk_eq("R1 reset retry", retry_cnt_o, 0);
        chk_eq("R1 reset excess", excess_coll_o, 0);
        repeat (30) step();
        chk_eq("R1 idle without frame req", req_o, 0);
        chk_eq("R1 idle without frame pops", pop_cnt, 0);
    endtask

    task automatic t_clean();
        int base, p0, d0;
        grant_i = 1'b1;
        p0 = pop_cnt;
        d0 = done_cnt;
        add_frame(3, base);
        chk_eq("R2 req low in add cycle", req_o, 0);
        step();
        chk_eq("R2 req rises next cycle", req_o, 1);
        wait_done(d0 + 1, "R9 clean");
        chk_eq("R2 req held in done cycle", req_o, 1);
        chk_eq("R9 done pulse", frame_done_o, 1);
        check_stream("R4 clean", base, 3);
        chk_eq("R4 first slot of frame", cap_ph, 3);
        chk_eq("R9 one pop per byte", pop_cnt - p0, 3);
        step();
        chk_eq("R2 req drops after done", req_o, 0);
        chk_eq("R9 single done pulse", done_cnt - d0, 1);
    endtask

    task automatic t_sync_only();
        int base, d0, f, g;
        grant_i = 1'b0;
        d0 = done_cnt;
        add_frame(2, base);
        repeat (25) step();
        chk_eq("R3 no start without grant", txen_o, 0);
        chk_eq("R2 req held while denied", req_o, 1);
        g = 0;
        while (ph != 1 && g < 20) begin
            step();
            g++;
        end
        f = frame_no;
        grant_i = 1'b1;
        repeat (4) step();
        chk_eq("R3 late grant ignored in frame", txen_o, 0);
        wait_done(d0 + 1, "R3 sync only");
        chk_eq("R3 start frame", cap_fr, f + 1);
        chk_eq("R4 start slot", cap_ph, 3);
        check_stream("R4 after denial", base, 2);
        step();
    endtask

    task automatic t_early();
        int base, d0, r0;
        grant_i = 1'b1;
        d0 = done_cnt;
        r0 = rew_cnt;
        add_frame(12, base);
        wait_bits(64, "R6 early");
        step();
        grant_i = 1'b0;
        step();
        chk_eq("R5 txen off after grant loss", txen_o, 0);
        chk_eq("R5 line idle after grant loss", txd_o, 1);
        chk_eq("R6 rewind pulse at 8 bytes", src_rewind_o, 1);
        chk_eq("R6 no late at 8 bytes", late_coll_o, 0);
        chk_eq("R2 req held in abort", req_o, 1);
        grant_i = 1'b1;
        step();
        chk_eq("R8 retry count one", retry_cnt_o, 1);
        chk_eq("R6 single rewind", rew_cnt - r0, 1);
        wait_done(d0 + 1, "R6 early");
        check_stream("R6 replay whole frame", base, 12);
        chk_eq("R6 replay start slot", cap_ph, 3);
        step();
        chk_eq("R8 retry cleared by done", retry_cnt_o, 0);
    endtask

    task automatic t_late();
        int base, p0, l0, r0;
        grant_i = 1'b1;
        l0 = late_cnt;
        r0 = rew_cnt;
        add_frame(12, base);
        wait_bits(72, "R7 late");
        step();
        grant_i = 1'b0;
        step();
        chk_eq("R7 late pulse at 9 bytes", late_coll_o, 1);
        chk_eq("R7 no rewind at 9 bytes", src_rewind_o, 0);
        step();
        chk_eq("R7 req low after abandon", req_o, 0);
        grant_i = 1'b1;
        p0 = pop_cnt;
        repeat (40) step();
        chk_eq("R7 nothing popped after abandon", pop_cnt - p0, 0);
        chk_eq("R7 stays idle", req_o, 0);
        chk_eq("R7 single late pulse", late_cnt - l0, 1);
        chk_eq("R7 rewinds", rew_cnt - r0, 0);
        chk_eq("R8 retry after late", retry_cnt_o, 0);
    endtask

    task automatic t_excess();
        int base, d0;
        grant_i = 1'b1;
        d0 = done_cnt;
        add_frame(2, base);
        for (int k = 1; k <= 16; k++) begin
            wait_bits(4, "R8 excess");
            step();
            grant_i = 1'b0;
            step();
            grant_i = 1'b1;
            step();
            if (k == 1 || k == 14 || k == 15 || k == 16) begin
                chk_eq($sformatf("R8 retry after %0d", k), retry_cnt_o, (k > 15) ? 15 : k);
                chk_eq($sformatf("R8 excess after %0d", k), excess_coll_o, int'(k >= 15));
            end
        end
        wait_done(d0 + 1, "R8 excess");
        check_stream("R6 replay after many", base, 2);
        step();
        chk_eq("R8 excess cleared", excess_coll_o, 0);
        chk_eq("R8 retry cleared", retry_cnt_o, 0);
    endtask

    task automatic t_back2back();
        int b1, b2, d0, p0, q0;
        grant_i = 1'b1;
        d0 = done_cnt;
        p0 = pop_cnt;
        add_frame(2, b1);
        add_frame(3, b2);
        step();
        q0 = reqlow_cnt;
        wait_done(d0 + 1, "R2 first of pair");
        check_stream("R4 first of pair", b1, 2);
        wait_done(d0 + 2, "R2 second of pair");
        chk_eq("R2 no req gap between frames", reqlow_cnt - q0, 0);
        check_stream("R4 second of pair", b2, 3);
        chk_eq("R9 pops for pair", pop_cnt - p0, 5);
        step();
        chk_eq("R2 req drops after pair", req_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'h00;
            lastm[i] = 1'b0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_clean();
        t_sync_only();
        t_early();
        t_late();
        t_excess();
        t_back2back();
        chk_eq("R1 line high whenever not sending", idle_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule